// File: doc/BRIEF.md
# Dual-Clock Operating-System Timer with Access Handshake

This block is a memory-mapped system timer split across two clocks. A 32-bit free-running counter and four comparators run on a slow timer clock. The register port runs on a faster bus clock. Every value that software writes to the counter or to a comparator crosses into the timer clock through a toggle request/acknowledge handshake. While that crossing is in flight, a per-register pending flag is visible in an access-status register. The counter cannot be read directly. Software first asks for a snapshot through the control register, waits for the snapshot pending flag to drop, and then reads the captured value.

Each comparator raises a status flag in the bus domain when the counter steps onto its value. Software clears the flags by writing ones to the status register. The interrupt output is high while any flag whose enable bit is set is still raised. Software treats a target fewer than 16 counts ahead of the current count as already missed, so the timer clock is expected to run near 3 MHz and well below the bus clock.

Each crossing is a small two-state machine on the bus side. XF_IDLE moves to XF_BUSY when a write or a snapshot request is accepted. XF_BUSY moves back to XF_IDLE once the returning acknowledge toggle equals the request toggle. A write that arrives while the machine is in XF_BUSY is discarded.

Top module: `ostmr_top`

## Requirements
- R1: After reset the following hold. All four comparator registers read 0xFFFFFFFF. The status, interrupt-enable, control and access-status registers read 0. `irq` is low. A count snapshot taken with the counter still disabled returns 0.
- R2: The byte offsets are comparator n at 4*n (n = 0..3), count 0x10, status 0x14, interrupt enable 0x1C, control 0x20 and access status 0x24. Reads of every register other than count return the bus-side copy at once, combinationally from `bus_addr`. Interrupt enable keeps bits 3:0, and control keeps bit 0.
- R3: A control write with bit 1 set requests a count snapshot, so writing 3 enables the counter and requests a snapshot. Access-status bit 5 is set from the next bus cycle until the timer-domain value has been captured and returned. After that, reads of offset 0x10 return the captured count.
- R4: A write to count sets access-status bit 4. A write to comparator n sets access-status bit n. Each bit clears on its own once the value has been taken into the timer domain.
- R5: A write to count or to a comparator whose pending bit is still set is dropped. The value that was pending is the one that takes effect.
- R6: Control bit 0 enables counting. While enabled, the counter advances by one per timer clock and wraps from 0xFFFFFFFF to 0. While disabled, it holds its value.
- R7: Status bit n is set when the enabled counter steps onto a value equal to comparator n. Comparators that the counter has not reached stay clear.
- R8: Writing status clears every bit written as 1. Bits written as 0 are not changed.
- R9: Interrupt-enable bit n gates status bit n onto `irq`. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Once its pending bit has cleared, a count write loads the counter with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| tmr_clk | input | 1 | Slow timer clock for counter and comparators |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_we | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Enabled match interrupt, bus domain |

## Verification
The hardest conditions to reach from the ports are a second write landing while the first is still crossing, and a comparator hit across the counter wrap. The bench issues a back-to-back pair of count writes, and a pair of comparator writes, one bus cycle apart. It then uses a snapshot and a read-back to show that only the first value took effect. For the wrap case it loads the counter with 0xFFFFFFFF while counting is disabled, places comparator 2 at 1, and enables counting briefly. It then checks that only flag 2 rose and that the frozen snapshot is a small wrapped value. Random comparator values, random count loads and random status clear masks drawn from a fixed seed fill in the ordinary cases.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    localparam logic [5:0] OFS_COUNT  = 6'h10;
    localparam logic [5:0] OFS_STATUS = 6'h14;
    localparam logic [5:0] OFS_IEN    = 6'h1C;
    localparam logic [5:0] OFS_CTRL   = 6'h20;
    localparam logic [5:0] OFS_ACCESS = 6'h24;

    typedef enum logic {
        XF_IDLE,
        XF_BUSY
    } xfer_state_e;
endpackage

// File: rtl/ostmr_sync2.sv
module ostmr_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/ostmr_wxfer.sv
module ostmr_wxfer
    import ostmr_pkg::*;
#(
    parameter int unsigned W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         src_wr,
    input  logic [W-1:0] src_data,
    output logic         pending,
    output logic [W-1:0] held,
    output logic         dst_load,
    output logic [W-1:0] dst_data
);
    xfer_state_e state_q, state_nxt;
    logic         req_tgl_q;
    logic         ack_s;
    logic         take;
    logic [W-1:0] data_q;
    logic         req_s;
    logic         seen_q;

    ostmr_sync2 #(.W(1)) u_ack_sync (.clk(src_clk), .rst_n(rst_n), .d(seen_q), .q(ack_s));
    ostmr_sync2 #(.W(1)) u_req_sync (.clk(dst_clk), .rst_n(rst_n), .d(req_tgl_q), .q(req_s));

    always_comb begin
        state_nxt = state_q;
        take      = 1'b0;
        unique case (state_q)
            XF_IDLE: if (src_wr) begin
                state_nxt = XF_BUSY;
                take      = 1'b1;
            end
            XF_BUSY: if (ack_s == req_tgl_q) state_nxt = XF_IDLE;
            default: state_nxt = XF_IDLE;
        endcase
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= XF_IDLE;
            req_tgl_q <= 1'b0;
            data_q    <= RST_VAL;
        end else begin
            state_q <= state_nxt;
            if (take) begin
                data_q    <= src_data;
                req_tgl_q <= ~req_tgl_q;
            end
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    assign pending  = (state_q == XF_BUSY);
    assign held     = data_q;
    assign dst_load = req_s ^ seen_q;
    assign dst_data = data_q;

    assert_pend_set_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
        (!pending && src_wr) |=> pending);
    assert_drop_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
        (pending && src_wr) |=> $stable(data_q));
endmodule

// File: rtl/ostmr_snap.sv
module ostmr_snap
    import ostmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         src_req,
    input  logic [W-1:0] dst_value,
    output logic         pending,
    output logic [W-1:0] snap_val
);
    xfer_state_e state_q, state_nxt;
    logic         req_tgl_q;
    logic         ack_s;
    logic         take;
    logic         done;
    logic         req_s;
    logic         seen_q;
    logic [W-1:0] cap_q;
    logic [W-1:0] val_q;

    ostmr_sync2 #(.W(1)) u_ack_sync (.clk(src_clk), .rst_n(rst_n), .d(seen_q), .q(ack_s));
    ostmr_sync2 #(.W(1)) u_req_sync (.clk(dst_clk), .rst_n(rst_n), .d(req_tgl_q), .q(req_s));

    always_comb begin
        state_nxt = state_q;
        take      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            XF_IDLE: if (src_req) begin
                state_nxt = XF_BUSY;
                take      = 1'b1;
            end
            XF_BUSY: if (ack_s == req_tgl_q) begin
                state_nxt = XF_IDLE;
                done      = 1'b1;
            end
            default: state_nxt = XF_IDLE;
        endcase
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= XF_IDLE;
            req_tgl_q <= 1'b0;
            val_q     <= '0;
        end else begin
            state_q <= state_nxt;
            if (take) req_tgl_q <= ~req_tgl_q;
            if (done) val_q <= cap_q;
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            seen_q <= req_s;
            if (req_s ^ seen_q) cap_q <= dst_value;
        end
    end

    assign pending  = (state_q == XF_BUSY);
    assign snap_val = val_q;

    assert_snap_hold_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(val_q));
    assert_snap_set_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
        (!pending && src_req) |=> pending);
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_CMP = 4,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              bus_clk,
    input  logic              tmr_clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned AS_CNT_BIT  = NUM_CMP;
    localparam int unsigned AS_SNAP_BIT = NUM_CMP + 1;
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic [NUM_CMP-1:0] wr_cmp;
    logic               wr_cnt, wr_sts, wr_ien, wr_ctl;
    logic [NUM_CMP-1:0] cmp_pend, cmp_ld;
    logic [DATA_W-1:0]  cmp_bus [NUM_CMP];
    logic [DATA_W-1:0]  cmp_dat [NUM_CMP];
    logic               cnt_pend, cnt_ld, snap_pend;
    logic [DATA_W-1:0]  cnt_bus, cnt_dat, snap_val;
    logic               ctl_en_q, en_s;
    logic [NUM_CMP-1:0] ien_q, sts_q, hit_tgl_q, hit_s, hit_d_q, hit_edge, clr_mask;
    logic [DATA_W-1:0]  cnt_q, cnt_inc;
    logic [DATA_W-1:0]  cmp_t [NUM_CMP];

    assign wr_cnt = bus_we && (bus_addr == OFS_COUNT);
    assign wr_sts = bus_we && (bus_addr == OFS_STATUS);
    assign wr_ien = bus_we && (bus_addr == OFS_IEN);
    assign wr_ctl = bus_we && (bus_addr == OFS_CTRL);

    for (genvar n = 0; n < NUM_CMP; n++) begin : g_cmp
        assign wr_cmp[n] = bus_we && (bus_addr == ADDR_W'(4 * n));
        ostmr_wxfer #(.W(DATA_W), .RST_VAL(ALL_ONES)) u_cmp_xfer (
            .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
            .src_wr(wr_cmp[n]), .src_data(bus_wdata),
            .pending(cmp_pend[n]), .held(cmp_bus[n]),
            .dst_load(cmp_ld[n]), .dst_data(cmp_dat[n]));
    end

    ostmr_wxfer #(.W(DATA_W), .RST_VAL('0)) u_cnt_xfer (
        .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
        .src_wr(wr_cnt), .src_data(bus_wdata),
        .pending(cnt_pend), .held(cnt_bus),
        .dst_load(cnt_ld), .dst_data(cnt_dat));

    ostmr_snap #(.W(DATA_W)) u_snap (
        .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
        .src_req(wr_ctl && bus_wdata[1]), .dst_value(cnt_q),
        .pending(snap_pend), .snap_val(snap_val));

    ostmr_sync2 #(.W(1))       u_en_sync  (.clk(tmr_clk), .rst_n(rst_n), .d(ctl_en_q),  .q(en_s));
    ostmr_sync2 #(.W(NUM_CMP)) u_hit_sync (.clk(bus_clk), .rst_n(rst_n), .d(hit_tgl_q), .q(hit_s));

    // Timer domain: counter and comparators
    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            hit_tgl_q <= '0;
            for (int n = 0; n < NUM_CMP; n++) cmp_t[n] <= ALL_ONES;
        end else begin
            if (cnt_ld)    cnt_q <= cnt_dat;
            else if (en_s) cnt_q <= cnt_inc;
            for (int n = 0; n < NUM_CMP; n++) begin
                if (cmp_ld[n]) cmp_t[n] <= cmp_dat[n];
                if (en_s && !cnt_ld && (cnt_inc == cmp_t[n])) hit_tgl_q[n] <= ~hit_tgl_q[n];
            end
        end
    end

    // Bus domain: control, enables, status
    assign hit_edge = hit_s ^ hit_d_q;
    assign clr_mask = wr_sts ? bus_wdata[NUM_CMP-1:0] : '0;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_q <= 1'b0;
            ien_q    <= '0;
            sts_q    <= '0;
            hit_d_q  <= '0;
        end else begin
            hit_d_q <= hit_s;
            sts_q   <= (sts_q & ~clr_mask) | hit_edge;
            if (wr_ctl) ctl_en_q <= bus_wdata[0];
            if (wr_ien) ien_q <= bus_wdata[NUM_CMP-1:0];
        end
    end

    assign irq = |(sts_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_CMP; n++)
            if (bus_addr == ADDR_W'(4 * n)) bus_rdata = cmp_bus[n];
        if (bus_addr == OFS_COUNT)  bus_rdata = snap_val;
        if (bus_addr == OFS_STATUS) bus_rdata[NUM_CMP-1:0] = sts_q;
        if (bus_addr == OFS_IEN)    bus_rdata[NUM_CMP-1:0] = ien_q;
        if (bus_addr == OFS_CTRL)   bus_rdata[0] = ctl_en_q;
        if (bus_addr == OFS_ACCESS) begin
            bus_rdata[NUM_CMP-1:0]  = cmp_pend;
            bus_rdata[AS_CNT_BIT]   = cnt_pend;
            bus_rdata[AS_SNAP_BIT]  = snap_pend;
        end
    end

    assert_count_step_R6: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (en_s && !cnt_ld) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_count_hold_R6: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (!en_s && !cnt_ld) |=> $stable(cnt_q));
    assert_load_R10: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        cnt_ld |=> (cnt_q == $past(cnt_dat)));
    assert_flag_set_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (|hit_edge) |=> ((sts_q & $past(hit_edge)) == $past(hit_edge)));
    assert_w1c_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_sts && !(|hit_edge)) |=> ((sts_q & $past(bus_wdata[NUM_CMP-1:0])) == '0));
    assert_irq_off_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

// File: tb/ostmr_top_tb_top.sv
module ostmr_top_tb_top;
    localparam logic [5:0] A_CNT = 6'h10, A_STS = 6'h14, A_IEN = 6'h1C,
                           A_CTL = 6'h20, A_AS = 6'h24;

    logic bus_clk = 1'b0, tmr_clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;
    int n_chk = 0, n_fail = 0;
    bit reported = 0;

    always #4 bus_clk = ~bus_clk;
    always #15 tmr_clk = ~tmr_clk;

    ostmr_top dut_i (.bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    function automatic logic [3:0] exp_w1c(input logic [3:0] old, input logic [3:0] mask);
        return old & ~mask;
    endfunction

    function automatic int exp_ticks(input int bus_cycles);
        return (bus_cycles * 8) / 30;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input logic [31:0] mask);
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(A_AS, v);
            if ((v & mask) == 0) return;
        end
        chk(1'b0, "R4 pending never cleared", v, 32'h0);
    endtask

    task automatic snap(input bit en, output logic [31:0] v);
        logic [31:0] s;
        wr(A_CTL, {30'd0, 1'b1, en});
        rd(A_AS, s);
        chk(s[5] == 1'b1, "R3 snapshot pending bit5", s, 32'h20);
        wait_idle(32'h20);
        rd(A_CNT, v);
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (100000) @(posedge bus_clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        report();
        $finish;
    end

    initial begin
        logic [31:0] v, v2, r;
        void'($urandom(32'h5EED));
        repeat (4) @(posedge bus_clk);
        @(negedge bus_clk) rst_n = 1'b1;
        repeat (4) @(posedge tmr_clk);

        // R1 reset state
        for (int n = 0; n < 4; n++) begin
            rd(6'(4 * n), r);
            chk(r == 32'hFFFF_FFFF, "R1 comparator reset", r, 32'hFFFF_FFFF);
        end
        rd(A_STS, r); chk(r == 0, "R1 status reset", r, 0);
        rd(A_IEN, r); chk(r == 0, "R1 enable reset", r, 0);
        rd(A_CTL, r); chk(r == 0, "R1 control reset", r, 0);
        rd(A_AS, r);  chk(r == 0, "R1 access reset", r, 0);
        chk(irq == 1'b0, "R1 irq reset", {31'd0, irq}, 0);
        snap(1'b0, r); chk(r == 0, "R1 R3 reset count", r, 0);

        // R2 R4 random comparator writes
        for (int i = 0; i < 8; i++) begin
            v = $urandom;
            wr(6'(4 * (i % 4)), v);
            rd(A_AS, r);
            chk(r == (32'h1 << (i % 4)), "R4 comparator pending", r, 32'h1 << (i % 4));
            wait_idle(32'h3F);
            rd(A_AS, r); chk(r == 0, "R4 pending cleared", r, 0);
            rd(6'(4 * (i % 4)), r); chk(r == v, "R2 comparator readback", r, v);
        end
        for (int n = 0; n < 4; n++) begin
            wr(6'(4 * n), 32'hFFFF_FFFF);
            wait_idle(32'h3F);
        end
        v = $urandom; wr(A_IEN, v);
        rd(A_IEN, r); chk(r == {28'd0, v[3:0]}, "R2 enable readback", r, {28'd0, v[3:0]});
        wr(A_IEN, 0);

        // R10 R4 random count loads, counter disabled
        for (int i = 0; i < 4; i++) begin
            v = $urandom;
            wr(A_CNT, v);
            rd(A_AS, r); chk(r == 32'h10, "R4 count pending bit4", r, 32'h10);
            wait_idle(32'h10);
            snap(1'b0, r); chk(r == v, "R10 count load", r, v);
        end

        // R5 dropped writes
        v = 32'h1234_5678; v2 = 32'h8765_4321;
        wr(A_CNT, v); wr(A_CNT, v2);
        wait_idle(32'h10);
        snap(1'b0, r); chk(r == v, "R5 count second write dropped", r, v);
        wr(6'h0C, 32'hAAAA_0001); wr(6'h0C, 32'h5555_0002);
        wait_idle(32'h3F);
        rd(6'h0C, r); chk(r == 32'hAAAA_0001, "R5 comparator second write dropped", r, 32'hAAAA_0001);
        wr(6'h0C, 32'hFFFF_FFFF); wait_idle(32'h3F);

        // R6 counting rate and hold
        wr(A_CNT, 0); wait_idle(32'h10);
        wr(A_STS, 32'hF);
        wr(A_CTL, 1);
        rd(A_CTL, r); chk(r == 1, "R2 control readback", r, 1);
        repeat (299) @(negedge bus_clk);
        wr(A_CTL, 0);
        repeat (20) @(negedge bus_clk);
        snap(1'b0, r);
        chk((r > exp_ticks(300) - 5) && (r < exp_ticks(300) + 5), "R6 counting rate", r, exp_ticks(300));
        repeat (30) @(negedge bus_clk);
        snap(1'b0, v); chk(v == r, "R6 disabled holds", v, r);
        rd(A_STS, r); chk(r == 0, "R7 no hit below comparators", r, 0);

        // R6 R7 wrap with comparator 2 at 1
        wr(A_CNT, 32'hFFFF_FFFF); wait_idle(32'h10);
        wr(6'h08, 32'h1); wait_idle(32'h3F);
        wr(A_CTL, 1);
        repeat (60) @(negedge bus_clk);
        wr(A_CTL, 0);
        repeat (20) @(negedge bus_clk);
        snap(1'b0, r);
        chk((r > 1) && (r < 32'h40), "R6 wrap to small count", r, 32'h10);
        rd(A_STS, r); chk(r == 32'h4, "R7 only comparator 2 hit", r, 32'h4);

        // R9 gating
        chk(irq == 1'b0, "R9 irq low with no enables", {31'd0, irq}, 0);
        wr(A_IEN, 32'h1);
        @(negedge bus_clk); chk(irq == 1'b0, "R9 other enable ignored", {31'd0, irq}, 0);
        wr(A_IEN, 32'h4);
        @(negedge bus_clk); chk(irq == 1'b1, "R9 irq raised", {31'd0, irq}, 1);

        // R8 write-one-to-clear
        wr(A_STS, 32'h1);
        rd(A_STS, r); chk(r == {28'd0, exp_w1c(4'h4, 4'h1)}, "R8 zero bits kept", r, {28'd0, exp_w1c(4'h4, 4'h1)});
        wr(A_STS, 32'h4);
        rd(A_STS, r); chk(r == 0, "R8 flag cleared", r, 0);
        chk(irq == 1'b0, "R9 irq drops after clear", {31'd0, irq}, 0);

        // R7 R9 comparator 0 hit with its enable
        wr(A_CNT, 32'd100); wait_idle(32'h10);
        wr(6'h00, 32'd110); wait_idle(32'h3F);
        wr(A_IEN, 32'h1);
        wr(A_CTL, 1);
        repeat (100) @(negedge bus_clk);
        wr(A_CTL, 0);
        repeat (20) @(negedge bus_clk);
        rd(A_STS, r); chk(r == 32'h1, "R7 comparator 0 hit", r, 32'h1);
        chk(irq == 1'b1, "R9 match0 interrupt", {31'd0, irq}, 1);

        // R8 random masks sparing bit 0
        for (int i = 0; i < 4; i++) begin
            v = $urandom & 32'hE;
            wr(A_STS, v);
            rd(A_STS, r);
            chk(r == {28'd0, exp_w1c(4'h1, v[3:0])}, "R8 random mask", r, {28'd0, exp_w1c(4'h1, v[3:0])});
        end

        report();
        $finish;
    end
endmodule